// File: doc/BRIEF.md
# Capacitive Channel Conversion Sequencer

This block schedules conversions on up to two capacitive input channels. A configuration byte selects the operating mode and the enabled channels. The block picks the channel to convert and issues a one-cycle start strobe to an external converter. It times the conversion from a two-bit oversampling selector. The result arrives on a done strobe, and the block stores it in the per-channel data register. It also keeps a status byte: a ready flag per channel, a last-channel bit and a power-down bit.

The conversion time is counted in ticks of a parameterized counter, `TICKS_PER_MS` clock cycles per millisecond, so a bench can use short durations. A conversion finishes only when the timer has expired and a done strobe has been seen. The bus interface reports a read of a data register through a busy level and a channel select. While that read is active, a result for the same channel is discarded. When the read ends, the ready flag of that channel is released.

Top module: `cdc_conv_seq`

## Requirements
- R1: After reset, status reads 0x03, both data registers read 0x0000, the configuration readback reads 0x00 and `conv_start` is low.
- R2: In the configuration byte, bits 2:0 are the mode, bit 4 enables channel 1 and bit 3 enables channel 2. `cfg_rdata` returns {3'b000, ch1 enable, ch2 enable, mode}. Mode codes: 000 idle, 001 continuous, 010 single, 011 power-down, 101 offset calibration, 110 gain calibration; 100 and 111 are unused.
- R3: The conversion length L is 5, 20, 50 or 60 ms for oversampling codes 00, 01, 10 and 11, where one ms is `TICKS_PER_MS` cycles. The selector is sampled at start. A conversion completes on the first edge that is at least L cycles after the start edge and at or after the edge sampling `conv_done`. The next `conv_start` follows one cycle later, and `conv_start` is always a single-cycle pulse.
- R4: `conv_ch` is 0 for channel 1 and 1 for channel 2. In continuous mode with both channels enabled, conversions alternate starting with channel 1. With one channel enabled, that channel repeats.
- R5: Single mode converts each enabled channel once, channel 1 first, then sets the mode field to 000.
- R6: A completed conversion writes the result with bits 3:0 forced to 0 into the data register of its channel. It drives that channel's ready flag to 0 (status bit 0 for channel 1, bit 1 for channel 2) and sets status bit 2 to the channel.
- R7: If `rd_busy` is high with `rd_ch` equal to the finishing channel, the result is dropped. The data register, the ready flag and status bit 2 keep their values.
- R8: A falling edge of `rd_busy` sets the ready flag of the channel last held on `rd_ch` back to 1.
- R9: Status bit 7 reads 1 in power-down mode or while `supply_low` is high. No conversion starts in power-down. Status bits 6:3 read 0.
- R10: In idle mode and in the unused modes 100 and 111, no conversion starts.
- R11: The calibration modes 101 and 110 convert each enabled channel once, channel 1 first, then return to mode 000. They leave the data registers and the status byte unchanged.
- R12: A configuration write aborts a conversion in progress, and its later done strobe is ignored. A done strobe with no conversion running changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte written |
| osr_sel | input | 2 | Oversampling / conversion-time selector |
| supply_low | input | 1 | Supply-low indication |
| rd_busy | input | 1 | Bus read of a data register in progress |
| rd_ch | input | 1 | Channel of the data register being read |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | DW | Converter result, valid with `conv_done` |
| conv_start | output | 1 | Start strobe to the converter |
| conv_ch | output | 1 | Channel being converted |
| cfg_rdata | output | 8 | Configuration readback |
| status | output | 8 | Status byte |
| data1 | output | DW | Channel 1 data register |
| data2 | output | DW | Channel 2 data register |

## Verification
A wrong alternation pointer or a wrong pending mask shows on `conv_ch` at the next start strobe, one cycle after the previous conversion ends. A wrong timer shows as a start-to-start spacing that differs from the oversampling length. A ready flag or last-channel bit left in the wrong state appears in `status` on the edge where the result lands. A missed read-block shows as a data register that changes while the read is active. A mode field that never returns to idle shows in `cfg_rdata`, and a further start strobe follows one cycle later.

// File: rtl/cdc_conv_seq.sv
module cdc_conv_seq #(
  parameter int TICKS_PER_MS = 1000,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  input  logic [1:0]    osr_sel,
  input  logic          supply_low,
  input  logic          rd_busy,
  input  logic          rd_ch,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_result,
  output logic          conv_start,
  output logic          conv_ch,
  output logic [7:0]    cfg_rdata,
  output logic [7:0]    status,
  output logic [DW-1:0] data1,
  output logic [DW-1:0] data2
);
  localparam int MAXT = 60 * TICKS_PER_MS;
  localparam int TW = $clog2(MAXT + 1);
  localparam logic [2:0] M_IDLE = 3'b000, M_CONT = 3'b001, M_ONCE = 3'b010,
                         M_PDN = 3'b011, M_OCAL = 3'b101, M_GCAL = 3'b110;
  localparam logic [DW-1:0] KEEP = {{(DW-4){1'b1}}, 4'b0000};

  logic [2:0]    mode;
  logic [1:0]    en, pend, rdy, avail, rest;
  logic          busy, cur, prev, got, last, start_q, rdb_q, rdch_q;
  logic [TW-1:0] tmr;
  logic [DW-1:0] res_q, d1_q, d2_q, res;
  logic          cont, once, cal, nxt, fin, blk;

  function automatic logic [TW-1:0] conv_len(input logic [1:0] s);
    case (s)
      2'd0:    return TW'(5 * TICKS_PER_MS);
      2'd1:    return TW'(20 * TICKS_PER_MS);
      2'd2:    return TW'(50 * TICKS_PER_MS);
      default: return TW'(60 * TICKS_PER_MS);
    endcase
  endfunction

  assign cont  = (mode == M_CONT);
  assign cal   = (mode == M_OCAL) || (mode == M_GCAL);
  assign once  = (mode == M_ONCE) || cal;
  assign avail = cont ? en : (once ? pend : 2'b00);
  assign nxt   = (avail == 2'b11) ? (cont ? ~prev : 1'b0) : avail[1];
  assign fin   = busy && (tmr == '0) && (got || conv_done);
  assign res   = conv_done ? conv_result : res_q;
  assign blk   = rd_busy && (rd_ch == cur);
  assign rest  = pend & ~(2'b01 << cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; en <= 2'b00; pend <= 2'b00; rdy <= 2'b11;
      busy <= 1'b0; cur <= 1'b0; prev <= 1'b1; got <= 1'b0; last <= 1'b0;
      start_q <= 1'b0; rdb_q <= 1'b0; rdch_q <= 1'b0;
      tmr <= '0; res_q <= '0; d1_q <= '0; d2_q <= '0;
    end else begin
      start_q <= 1'b0;
      rdb_q   <= rd_busy;
      if (rd_busy) rdch_q <= rd_ch;
      if (rdb_q && !rd_busy) rdy[rdch_q] <= 1'b1;
      if (cfg_wr) begin
        mode <= cfg_wdata[2:0];
        en   <= {cfg_wdata[3], cfg_wdata[4]};
        pend <= {cfg_wdata[3], cfg_wdata[4]};
        busy <= 1'b0;
        got  <= 1'b0;
        prev <= 1'b1;
      end else if (!busy) begin
        if (avail != 2'b00) begin
          busy    <= 1'b1;
          start_q <= 1'b1;
          cur     <= nxt;
          prev    <= nxt;
          tmr     <= conv_len(osr_sel) - 1'b1;
          got     <= 1'b0;
        end else if (once) begin
          mode <= M_IDLE;
        end
      end else begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        if (conv_done) begin
          got   <= 1'b1;
          res_q <= conv_result;
        end
        if (fin) begin
          busy <= 1'b0;
          got  <= 1'b0;
          if (!cal && !blk) begin
            if (cur) d2_q <= res & KEEP;
            else     d1_q <= res & KEEP;
            rdy[cur] <= 1'b0;
            last     <= cur;
          end
          if (once) begin
            pend <= rest;
            if (rest == 2'b00) mode <= M_IDLE;
          end
        end
      end
    end
  end

  assign conv_start = start_q;
  assign conv_ch    = cur;
  assign cfg_rdata  = {3'b000, en[0], en[1], mode};
  assign status     = {(mode == M_PDN) || supply_low, 4'b0000, last, rdy[1], rdy[0]};
  assign data1      = d1_q;
  assign data2      = d2_q;
endmodule

// File: rtl/cdc_conv_seq_chk.sv
module cdc_conv_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic          rd_busy,
  input logic          rd_ch,
  input logic [7:0]    cfg_rdata,
  input logic [7:0]    status,
  input logic [DW-1:0] data1,
  input logic [DW-1:0] data2
);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R9
  pdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[2:0] == 3'b011) |-> !conv_start);

  // R6
  data1_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data1) |-> (status[0] == 1'b0 && status[2] == 1'b0));

  // R6
  data2_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data2) |-> (status[1] == 1'b0 && status[2] == 1'b1));

  // R7
  rd_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !rd_ch) |=> $stable(data1));

  // R7
  rd_hold2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && rd_ch) |=> $stable(data2));
endmodule

bind cdc_conv_seq cdc_conv_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .rd_busy(rd_busy),
  .rd_ch(rd_ch), .cfg_rdata(cfg_rdata), .status(status),
  .data1(data1), .data2(data2)
);

// File: tb/sim_cdc_conv_seq.sv
module sim_cdc_conv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TPM = 2;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [1:0]    osr_sel = '0;
  logic          supply_low = 1'b0;
  logic          rd_busy = 1'b0;
  logic          rd_ch = 1'b0;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_result = '0;
  logic          conv_start, conv_ch;
  logic [7:0]    cfg_rdata, status;
  logic [DW-1:0] data1, data2;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] exp_d1 = '0, exp_d2 = '0;
  logic [1:0]    exp_rdy = 2'b11;
  logic          exp_last = 1'b0;
  bit            prev_valid = 0;
  int            prev_at = 0, prev_per = 0;

  cdc_conv_seq #(.TICKS_PER_MS(TPM), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .osr_sel(osr_sel), .supply_low(supply_low), .rd_busy(rd_busy), .rd_ch(rd_ch),
    .conv_done(conv_done), .conv_result(conv_result), .conv_start(conv_start),
    .conv_ch(conv_ch), .cfg_rdata(cfg_rdata), .status(status),
    .data1(data1), .data2(data2)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int clen(input logic [1:0] s);
    case (s)
      2'd0:    return 5 * TPM;
      2'd1:    return 20 * TPM;
      2'd2:    return 50 * TPM;
      default: return 60 * TPM;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {1'b0, 4'b0000, exp_last, exp_rdy[1], exp_rdy[0]};
  endfunction

  task automatic write_cfg(input logic [2:0] m, input bit e1, input bit e2);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = {3'b000, e1, e2, m};
    @(negedge clk);
    cfg_wr = 1'b0;
    prev_valid = 0;
  endtask

  task automatic no_start(input int n, input string req);
    int c;
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (conv_start) c++;
    end
    chk(c == 0, req, c, 0);
  endtask

  task automatic do_conv(input bit exp_ch, input int d, input logic [DW-1:0] v,
                         input bit blk, input bit cal);
    bit seen;
    int at, L, fin;
    seen = 0;
    at = 0;
    for (int i = 0; i < 400; i++) begin
      if (conv_start) begin
        seen = 1;
        at = cyc;
        break;
      end
      @(negedge clk);
    end
    chk(seen, "R3 start strobe", seen, 1);
    if (!seen) return;
    chk(conv_ch == exp_ch, "R4 channel order", conv_ch, exp_ch);
    if (prev_valid) chk(at - prev_at == prev_per, "R3 start spacing", at - prev_at, prev_per);
    L = clen(osr_sel);
    fin = (L > d + 1) ? L : d + 1;
    if (blk) begin
      rd_busy = 1'b1;
      rd_ch = exp_ch;
    end
    repeat (d) @(negedge clk);
    conv_done = 1'b1;
    conv_result = v;
    @(negedge clk);
    conv_done = 1'b0;
    conv_result = DW'($urandom);
    repeat (fin - d - 1) @(negedge clk);
    if (!cal && !blk) begin
      if (exp_ch) exp_d2 = v & 16'hFFF0;
      else        exp_d1 = v & 16'hFFF0;
      exp_rdy[exp_ch] = 1'b0;
      exp_last = exp_ch;
    end
    chk(data1 == exp_d1, blk ? "R7 data1" : (cal ? "R11 data1" : "R6 data1"), data1, exp_d1);
    chk(data2 == exp_d2, blk ? "R7 data2" : (cal ? "R11 data2" : "R6 data2"), data2, exp_d2);
    chk(status == exp_status(), blk ? "R7 status" : (cal ? "R11 status" : "R6 status"),
        status, exp_status());
    if (blk) begin
      rd_busy = 1'b0;
      exp_rdy[exp_ch] = 1'b1;
    end
    prev_at = at;
    prev_per = fin + 1;
    prev_valid = 1;
  endtask

  task automatic do_read(input bit ch);
    @(negedge clk);
    rd_busy = 1'b1;
    rd_ch = ch;
    @(negedge clk);
    @(negedge clk);
    rd_busy = 1'b0;
    @(negedge clk);
    exp_rdy[ch] = 1'b1;
    chk(status == exp_status(), "R8 ready released", status, exp_status());
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int L;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(status == 8'h03, "R1 status", status, 8'h03);
    chk(data1 == 0 && data2 == 0, "R1 data", {data1, data2}, 0);
    chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
    chk(!conv_start, "R1 start", conv_start, 0);
    no_start(50, "R10 idle quiet");

    // R2 / R10 unused codes
    write_cfg(3'b100, 1, 1);
    chk(cfg_rdata == 8'h1C, "R2 readback", cfg_rdata, 8'h1C);
    no_start(60, "R10 code 100");
    write_cfg(3'b111, 1, 0);
    chk(cfg_rdata == 8'h17, "R2 readback", cfg_rdata, 8'h17);
    no_start(60, "R10 code 111");

    // R4 continuous alternation, osr 00
    osr_sel = 2'd0;
    write_cfg(3'b001, 1, 1);
    L = clen(osr_sel);
    for (int i = 0; i < 6; i++)
      do_conv(i[0], $urandom_range(L - 2, 0), DW'($urandom), 0, 0);
    // R12 abort, late done ignored
    write_cfg(3'b000, 1, 1);
    @(negedge clk);
    conv_done = 1'b1;
    conv_result = 16'hABCD;
    @(negedge clk);
    conv_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(data1 == exp_d1 && data2 == exp_d2, "R12 abort keeps data", {data1, data2}, {exp_d1, exp_d2});
    chk(status == exp_status(), "R12 abort keeps status", status, exp_status());

    // R8
    do_read(1'b0);
    do_read(1'b1);

    // R3 late done, R7 block, channel 2 only
    osr_sel = 2'd1;
    write_cfg(3'b001, 0, 1);
    L = clen(osr_sel);
    do_conv(1'b1, 3, 16'h1234, 0, 0);
    do_conv(1'b1, L + 3, 16'h5678, 0, 0);
    do_conv(1'b1, 7, 16'h9ABC, 1, 0);
    do_conv(1'b1, 0, 16'hFFFF, 0, 0);
    write_cfg(3'b000, 0, 1);

    // R5 single, osr 10
    osr_sel = 2'd2;
    write_cfg(3'b010, 1, 1);
    do_conv(1'b0, 10, 16'h0F0F, 0, 0);
    do_conv(1'b1, 20, 16'hF0F7, 0, 0);
    chk(cfg_rdata[2:0] == 3'b000, "R5 back to idle", cfg_rdata[2:0], 0);
    no_start(150, "R5 no more starts");

    // R11 calibration
    osr_sel = 2'd3;
    write_cfg(3'b101, 1, 0);
    do_conv(1'b0, 5, 16'h4444, 0, 1);
    chk(cfg_rdata[2:0] == 3'b000, "R11 offset cal idle", cfg_rdata[2:0], 0);
    osr_sel = 2'd0;
    write_cfg(3'b110, 1, 1);
    do_conv(1'b0, 2, 16'h5555, 0, 1);
    do_conv(1'b1, 2, 16'h6666, 0, 1);
    chk(cfg_rdata[2:0] == 3'b000, "R11 gain cal idle", cfg_rdata[2:0], 0);
    no_start(40, "R11 no more starts");

    // R9
    write_cfg(3'b011, 1, 1);
    chk(status[7] == 1'b1, "R9 pwdn in power-down", status, {1'b1, exp_status()});
    chk(status[6:3] == 4'b0000, "R9 zero bits", status[6:3], 0);
    no_start(100, "R9 no starts");
    write_cfg(3'b000, 1, 1);
    chk(status[7] == 1'b0, "R9 pwdn cleared", status[7], 0);
    supply_low = 1'b1;
    @(negedge clk);
    chk(status[7] == 1'b1, "R9 supply low", status[7], 1);
    supply_low = 1'b0;
    @(negedge clk);
    chk(status[7] == 1'b0, "R9 supply ok", status[7], 0);

    // R12 stray done in idle
    conv_done = 1'b1;
    conv_result = 16'h7777;
    @(negedge clk);
    conv_done = 1'b0;
    repeat (2) @(negedge clk);
    chk(data1 == exp_d1 && data2 == exp_d2, "R12 stray done", {data1, data2}, {exp_d1, exp_d2});

    // random continuous rounds
    for (int r = 0; r < 6; r++) begin
      bit e1, e2, ch;
      e1 = 1'($urandom);
      e2 = 1'($urandom);
      if (!e1 && !e2) e1 = 1;
      osr_sel = 2'($urandom_range(1, 0));
      write_cfg(3'b001, e1, e2);
      L = clen(osr_sel);
      ch = !e1;
      for (int k = 0; k < 5; k++) begin
        do_conv(ch, $urandom_range(L + 4, 0), DW'($urandom), ($urandom_range(3, 0) == 0), 0);
        if (e1 && e2) ch = ~ch;
      end
      write_cfg(3'b000, e1, e2);
    end

    summary();
    $finish;
  end
endmodule